// File: doc/BRIEF.md
# Half-Duplex Serial Result Port for a Two-Channel Converter

This block is the device end of a serial link that a host uses to configure a two-channel, 12-bit converter and then read its result. The host pulls the select line low and keeps its data line at 0 until it sends a single 1, the start marker. It then clocks in three configuration bits and clocks out the result. The block sends one zero null bit first, then the result in the order that the configuration asked for. The inbound phase always ends before the outbound phase begins, so the host may tie the data-in and data-out lines together and use a three-wire link. The block only enables its output driver once the inbound phase is over.

A fast system clock synchronises the select, serial clock and data inputs and looks for edges on the serial clock. A captured bit is taken on a rising serial edge and a launched bit is driven after a falling one. Two parallel sample words stand in for the analog front end. In differential mode the block reports the difference of the two words, clamped at zero.

Top module: `adc_halfduplex_slave`

## Requirements
- R1: After reset, and while the select line is high, `dout_oe` is 0 and `dout` is 0.
- R2: After select goes low, 0 bits sampled on `din` are ignored. The first 1 sampled at a rising serial edge is the start marker.
- R3: The three bits captured at the rising edges after the start marker form the configuration, in this order: mode (1 = single-ended, 0 = differential), then channel/polarity select, then bit order (1 = MSB first). `dout_oe` stays 0 for the whole inbound phase.
- R4: In single-ended mode, select 0 reports `samp0` and select 1 reports `samp1`.
- R5: In differential mode, select 0 reports `samp0 - samp1` and select 1 reports `samp1 - samp0`. The result is clamped to 0 when the difference is negative.
- R6: The falling serial edge after the third configuration bit asserts `dout_oe` and drives a 0 null bit.
- R7: With bit order 1, the slots after the null bit carry B11 down to B0, then B1 up to B11 (B0 is shared), then zeros for as long as the clock runs.
- R8: With bit order 0, the slots after the null bit carry B0 up to B11, then zeros.
- R9: The reported word is taken from the sample inputs when the last configuration bit is received. Later changes to `samp0`/`samp1` do not alter the bits being shifted out.
- R10: `din` is ignored during the outbound phase. Tying `din` to the driven data line gives the same result as a separate input wire.
- R11: Raising select during a transfer aborts it. The next transfer starts a fresh search for the start marker.
- R12: `dout` changes only after a falling serial edge. It is stable while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| samp0 | input | DW | Channel 0 sample word |
| samp1 | input | DW | Channel 1 sample word |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Output driver enable for `dout` |

## Verification
The bench places leading zeros before the start marker. A design that treated the first sampled bit as the marker would read them as configuration and report the wrong channel. It ties the data lines together, and in separate-wire runs it toggles `din` during read-back. An output enable that came one edge early, or an input stage that kept listening, would then corrupt the result. Both bit orders are checked far past the last data bit, which exposes a missing shared B0 or a missing zero fill. Differential reads with a negative difference, a select abort in the middle of the configuration, and a change of the sample words during read-back cover the clamp, the restart and the latching.

// File: rtl/adc_hd_pkg.sv
package adc_hd_pkg;

   typedef enum logic [1:0] {
      RX_HUNT = 2'd0,
      RX_CFG  = 2'd1,
      RX_HOLD = 2'd2
   } rx_state_e;

   typedef struct packed {
      logic single_end;
      logic chan_sel;
      logic msb_first;
   } hd_cfg_t;

   localparam int CFG_BITS = $bits(hd_cfg_t);

endpackage

// File: rtl/hd_sync.sv
module hd_sync #(
   parameter int            W       = 3,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hd_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= {STAGES{RST_VAL[g]}};
         else        sh <= {sh[STAGES-2:0], d[g]};
      end
      assign q[g] = sh[STAGES-1];
   end

endmodule

// File: rtl/hd_sclk_edge.sv
module hd_sclk_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_s,
   input  logic idle,
   output logic rise,
   output logic fall
);

   logic sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign rise = !idle &&  sclk_s && !sclk_q;
   assign fall = !idle && !sclk_s &&  sclk_q;

endmodule

// File: rtl/hd_cmd_rx.sv
module hd_cmd_rx
   import adc_hd_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    idle,
   input  logic    rise,
   input  logic    din_s,
   output hd_cfg_t cfg,
   output logic    cfg_load,
   output logic    busy,
   output logic    ready
);

   localparam int CW = (CFG_BITS > 1) ? $clog2(CFG_BITS) : 1;

   rx_state_e             state;
   logic [CW-1:0]         cnt;
   logic [CFG_BITS-1:0]   shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_HUNT;
         cnt      <= '0;
         shreg    <= '0;
         cfg_load <= 1'b0;
      end else if (idle) begin
         state    <= RX_HUNT;
         cnt      <= '0;
         cfg_load <= 1'b0;
      end else begin
         cfg_load <= 1'b0;
         if (rise) begin
            case (state)
               RX_HUNT: begin
                  if (din_s) begin
                     state <= RX_CFG;
                     cnt   <= '0;
                  end
               end
               RX_CFG: begin
                  shreg <= {shreg[CFG_BITS-2:0], din_s};
                  if (int'(cnt) == CFG_BITS - 1) begin
                     state    <= RX_HOLD;
                     cfg_load <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= RX_HOLD;
            endcase
         end
      end
   end

   assign cfg   = hd_cfg_t'(shreg);
   assign busy  = (state != RX_HOLD);
   assign ready = (state == RX_HOLD);

   p_load_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |-> $past(rise));

   p_hunt_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_HUNT && rise && !din_s && !idle) |=> (state == RX_HUNT));

endmodule

// File: rtl/hd_result_sel.sv
module hd_result_sel
   import adc_hd_pkg::*;
#(
   parameter int DW      = 12,
   parameter bit DIFF_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  hd_cfg_t       cfg,
   input  logic [DW-1:0] samp0,
   input  logic [DW-1:0] samp1,
   output logic [DW-1:0] word
);

   logic [DW-1:0] pos_w, neg_w, res;

   assign pos_w = cfg.chan_sel ? samp1 : samp0;
   assign neg_w = cfg.chan_sel ? samp0 : samp1;

   if (DIFF_EN) begin : g_diff
      always_comb begin
         if (cfg.single_end)     res = pos_w;
         else if (pos_w > neg_w) res = pos_w - neg_w;
         else                    res = '0;
      end
   end else begin : g_se_only
      logic unused_mode;
      assign unused_mode = cfg.single_end ^ (|neg_w);
      assign res = pos_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word <= '0;
      else if (load) word <= res;
   end

   p_diff_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !cfg.single_end) |=> (word <= $past(pos_w)));

endmodule

// File: rtl/hd_tx_shift.sv
module hd_tx_shift #(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idle,
   input  logic          fall,
   input  logic          ready,
   input  logic          msb_first,
   input  logic [DW-1:0] word,
   output logic          dout,
   output logic          oe
);

   localparam int LAST = 2 * DW;
   localparam int KW   = $clog2(LAST + 1);

   logic [KW-1:0] k;
   logic          nxt;

   function automatic logic sel_bit(input logic [DW-1:0] v, input int idx);
      logic b;
      b = 1'b0;
      for (int i = 0; i < DW; i++) if (i == idx) b = v[i];
      return b;
   endfunction

   always_comb begin
      int kk;
      kk  = int'(k);
      nxt = 1'b0;
      if (msb_first) begin
         if (kk >= 1 && kk <= DW)          nxt = sel_bit(word, DW - kk);
         else if (kk > DW && kk < LAST)    nxt = sel_bit(word, kk - DW);
      end else if (kk >= 1 && kk <= DW) begin
         nxt = sel_bit(word, kk - 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe   <= 1'b0;
         dout <= 1'b0;
         k    <= '0;
      end else if (idle) begin
         oe   <= 1'b0;
         dout <= 1'b0;
         k    <= '0;
      end else if (fall && ready) begin
         if (!oe) begin
            oe   <= 1'b1;
            dout <= 1'b0;
            k    <= KW'(1);
         end else begin
            dout <= nxt;
            if (int'(k) != LAST) k <= k + 1'b1;
         end
      end
   end

   p_dout_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (dout != $past(dout)) |-> ($past(fall) || $past(idle)));

   p_oe_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> ($past(fall) && $past(ready) && !dout));

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> (!oe && !dout));

endmodule

// File: rtl/adc_halfduplex_slave.sv
module adc_halfduplex_slave
   import adc_hd_pkg::*;
#(
   parameter int DW          = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit DIFF_EN     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          sclk,
   input  logic          din,
   input  logic [DW-1:0] samp0,
   input  logic [DW-1:0] samp1,
   output logic          dout,
   output logic          dout_oe
);

   if (DW < 2) begin : g_bad_dw
      $error("adc_halfduplex_slave: DW must be at least 2");
   end

   logic    cs_s, sclk_s, din_s;
   logic    rise, fall;
   hd_cfg_t cfg;
   logic    cfg_load, rx_busy, rx_ready;
   logic [DW-1:0] word;

   hd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, din}),
      .q     ({cs_s, sclk_s, din_s})
   );

   hd_sclk_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_s (sclk_s),
      .idle   (cs_s),
      .rise   (rise),
      .fall   (fall)
   );

   hd_cmd_rx u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle     (cs_s),
      .rise     (rise),
      .din_s    (din_s),
      .cfg      (cfg),
      .cfg_load (cfg_load),
      .busy     (rx_busy),
      .ready    (rx_ready)
   );

   hd_result_sel #(.DW(DW), .DIFF_EN(DIFF_EN)) u_res (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cfg_load),
      .cfg   (cfg),
      .samp0 (samp0),
      .samp1 (samp1),
      .word  (word)
   );

   hd_tx_shift #(.DW(DW)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (cs_s),
      .fall      (fall),
      .ready     (rx_ready),
      .msb_first (cfg.msb_first),
      .word      (word),
      .dout      (dout),
      .oe        (dout_oe)
   );

   p_quiet_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy |-> !dout_oe);

endmodule

// File: tb/adc_halfduplex_slave_bench.sv
module adc_halfduplex_slave_bench;

   localparam int DW   = 12;
   localparam int HALF = 8;
   localparam int NRD  = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic host_bit = 1'b0;
   logic tied = 1'b0;
   logic [DW-1:0] s0 = '0, s1 = '0;
   logic dout, dout_oe, din_w;

   int nchk = 0;
   int nbad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   assign din_w = tied ? (dout_oe ? dout : host_bit) : host_bit;

   adc_halfduplex_slave u_adc_halfduplex_slave (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din_w),
      .samp0(s0), .samp1(s1), .dout(dout), .dout_oe(dout_oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [DW-1:0] ref_word(input bit se, input bit sel,
                                              input logic [DW-1:0] a, input logic [DW-1:0] b);
      int p, m;
      p = sel ? int'(b) : int'(a);
      m = sel ? int'(a) : int'(b);
      if (se) return DW'(p);
      return (p > m) ? DW'(p - m) : '0;
   endfunction

   task automatic send_bit(input logic b, input string req);
      host_bit = b;
      wait_clk(HALF);
      chk(dout_oe == 1'b0, req, int'(dout_oe), 0);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
   endtask

   task automatic xfer(input bit tw, input int lz, input bit se, input bit sel,
                       input bit msbf, input bit swap_mid, input string req);
      logic [DW-1:0] w;
      bit q[$];
      logic v;
      tied = tw;
      w = ref_word(se, sel, s0, s1);
      q.push_back(1'b0);
      if (msbf) begin
         for (int i = DW - 1; i >= 0; i--) q.push_back(w[i]);
         for (int i = 1; i < DW; i++)      q.push_back(w[i]);
      end else begin
         for (int i = 0; i < DW; i++) q.push_back(w[i]);
      end
      while (q.size() < NRD) q.push_back(1'b0);
      cs_n = 1'b0;
      wait_clk(4);
      for (int i = 0; i < lz; i++) send_bit(1'b0, "R2 lead zero");
      send_bit(1'b1, "R3 start");
      send_bit(se,   "R3 cfg mode");
      send_bit(sel,  "R3 cfg sel");
      send_bit(msbf, "R3 cfg order");
      for (int s = 0; s < NRD; s++) begin
         host_bit = ~host_bit;
         wait_clk(HALF);
         chk(dout_oe == 1'b1, (s == 0) ? "R6 oe at null" : "R10 oe held", int'(dout_oe), 1);
         chk(dout == q[s], {req, (s == 0) ? " R6 null bit" : " data slot"}, int'(dout), int'(q[s]));
         sclk = 1'b1;
         v = dout;
         if (swap_mid && s == 4) begin
            s0 = ~s0;
            s1 = ~s1;
         end
         wait_clk(HALF);
         chk(dout == v, "R12 stable while high", int'(dout), int'(v));
         sclk = 1'b0;
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(6);
      chk(dout_oe == 1'b0 && dout == 1'b0, "R11 release", int'({dout_oe, dout}), 0);
      tied = 1'b0;
      wait_clk(6);
   endtask

   initial begin : watchdog
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++;
         nbad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin : stim
      wait_clk(5);
      chk(dout_oe == 1'b0 && dout == 1'b0, "R1 reset", int'({dout_oe, dout}), 0);
      rst_n = 1'b1;
      wait_clk(5);
      chk(dout_oe == 1'b0, "R1 idle", int'(dout_oe), 0);

      s0 = 12'hA5C; s1 = 12'h3E1;
      xfer(1'b0, 0, 1'b1, 1'b0, 1'b1, 1'b0, "R4 R7 ch0 msb 4w");
      xfer(1'b0, 3, 1'b1, 1'b1, 1'b0, 1'b0, "R2 R8 ch1 lsb 4w");
      xfer(1'b1, 2, 1'b1, 1'b1, 1'b1, 1'b0, "R10 R7 ch1 msb tied");
      xfer(1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 R8 ch0 lsb tied");
      xfer(1'b1, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 diff pos tied");
      xfer(1'b0, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R5 diff clamp");
      s0 = 12'h123; s1 = 12'hF0F;
      xfer(1'b0, 1, 1'b0, 1'b1, 1'b1, 1'b0, "R5 diff sel1");

      cs_n = 1'b0;
      wait_clk(4);
      send_bit(1'b1, "R11 abort start");
      send_bit(1'b0, "R11 abort cfg");
      cs_n = 1'b1;
      wait_clk(6);
      chk(dout_oe == 1'b0, "R11 abort quiet", int'(dout_oe), 0);
      xfer(1'b0, 2, 1'b1, 1'b0, 1'b1, 1'b0, "R11 after abort");

      s0 = 12'h8F1; s1 = 12'h0C7;
      xfer(1'b0, 0, 1'b1, 1'b0, 1'b1, 1'b1, "R9 latch msb");
      s0 = 12'h8F1; s1 = 12'h0C7;
      xfer(1'b1, 0, 1'b1, 1'b1, 1'b0, 1'b1, "R9 latch lsb");

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

endmodule